// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates three interrupt sources for a small 8-bit processor core: one external request and two timer overflow events. Each source has an active-high enable, and one global enable gates them all. The core sees all of this through a single 8-bit register at data address 0x0B, which it can read and write. Hardware events set latched pending flags in that register. The core can clear a flag by writing 0 to it.

Arbitration happens only on cycles where the machine-cycle phase strobe is high. If the global enable is set, the stack is not full, and at least one enabled source is pending, the block grants the lowest-numbered pending source. On the next cycle it raises a one-cycle acknowledge and presents that source's vector. The same clock edge clears the global enable and the winner's flag. This holds off nested acknowledges until the core returns with enable or writes the global enable back to 1.

Top module: `prio_irq_unit`

## Requirements
- R1: After synchronous reset the register reads 0x00 and `irq_ack` is 0.
- R2: Register layout at address 0x0B: bit0 global enable; bits 1/2/3 are the enables for external, timer-0 and timer-1; bits 4/5/6 are their pending flags; bit7 always reads 0. Writes to any other address leave the register unchanged, and reads at any other address return 0x00.
- R3: A one-cycle event pulse sets the matching pending flag. The flag stays set until the source is acknowledged or the core writes 0 to it.
- R4: When several enabled sources are pending together, external wins with vector 0x04, then timer-0 with 0x08, then timer-1 with 0x0C.
- R5: A grant happens only on a clock edge where `phase_t2` is high. `irq_ack` and `irq_vec` then appear in the following cycle.
- R6: A grant clears the global enable and the winner's pending flag, and leaves the other flags set. `irq_ack` lasts exactly one cycle.
- R7: While the global enable is 0 no grant occurs, but flags still latch. A source whose own enable is 0 is never granted.
- R8: No grant occurs while `stack_full` is 1.
- R9: A `ret_en` pulse sets the global enable.
- R10: If an event pulse and a register write of 0 to the same flag fall in the same cycle, the flag ends up set.
- R11: After an acknowledge, further grants are held off until either `ret_en` or a register write sets the global enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Data-memory address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (register value when addressed, else 0) |
| ext_evt | input | 1 | External request pulse |
| tmr0_evt | input | 1 | Timer-0 overflow pulse |
| tmr1_evt | input | 1 | Timer-1 overflow pulse |
| phase_t2 | input | 1 | Machine-cycle phase strobe enabling arbitration |
| stack_full | input | 1 | Core stack has no free slot |
| ret_en | input | 1 | Return-with-enable executed by the core |
| irq_ack | output | 1 | One-cycle acknowledge |
| irq_vec | output | 8 | Vector address of the acknowledged source |

## Verification
Two pairs of functions can land on the same flag in the same cycle. The first pair is a software write and a hardware event. The bench provokes it by driving a write of 0 together with a timer-0 pulse on one edge, then reads the register back and expects the flag to be set. The second pair is a grant clearing a flag while the others stay latched. The bench raises all three events at once, expects vectors 0x04, 0x08 and 0x0C across successive re-enables, and reads the flag field after each acknowledge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NSRC      = 3;
    localparam int DW        = 8;
    localparam logic [DW-1:0] CTRL_ADDR = 8'h0B;
    localparam int VEC_SHIFT = 2;

    // bit7 pad, bits6..4 pending, bits3..1 source enables, bit0 global enable
    typedef struct packed {
        logic            pad;
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] src_en;
        logic            gie;
    } ctrl_t;

    typedef struct packed {
        logic            grant;
        logic [NSRC-1:0] win_oh;
        logic [DW-1:0]   vec;
    } arb_t;

    function automatic logic [DW-1:0] vec_of(input int idx);
        return DW'((idx + 1) << VEC_SHIFT);
    endfunction

endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import prio_irq_pkg::*;
(
    input  ctrl_t cur,
    input  logic  phase,
    input  logic  stack_full,
    output arb_t  arb
);
    logic [NSRC-1:0] req;

    always_comb begin
        req        = cur.pend & cur.src_en;
        arb        = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                arb.win_oh = '0;
                arb.win_oh[i] = 1'b1;
                arb.vec = vec_of(i);
            end
        end
        arb.grant = phase && cur.gie && (|req) && !stack_full;
        if (!arb.grant) begin
            arb.win_oh = '0;
        end
    end

    always_comb begin
        p_onehot_r4: assert ($onehot0(arb.win_oh));
    end

endmodule

// File: rtl/pic_ctrl_reg.sv
module pic_ctrl_reg
    import prio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_hit,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] evt,
    input  logic            ret_en,
    input  arb_t            arb,
    output ctrl_t           q
);
    ctrl_t d;

    always_comb begin
        d = q;
        if (wr_hit) begin
            d = ctrl_t'(wdata);
        end
        d.pad = 1'b0;
        if (ret_en) begin
            d.gie = 1'b1;
        end
        if (arb.grant) begin
            d.gie  = 1'b0;
            d.pend = d.pend & ~arb.win_oh;
        end
        d.pend = d.pend | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    p_retset_r9: assert property (@(posedge clk) disable iff (rst)
        (ret_en && !arb.grant) |=> q.gie);
    p_evt_wins_r10: assert property (@(posedge clk) disable iff (rst)
        evt[1] |=> q.pend[1]);

endmodule

// File: rtl/prio_irq_unit.sv
module prio_irq_unit
    import prio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_evt,
    input  logic       tmr0_evt,
    input  logic       tmr1_evt,
    input  logic       phase_t2,
    input  logic       stack_full,
    input  logic       ret_en,
    output logic       irq_ack,
    output logic [7:0] irq_vec
);
    ctrl_t cur;
    arb_t  arb;
    logic  hit;

    assign hit = (bus_addr == CTRL_ADDR);

    pic_ctrl_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (bus_wr && hit),
        .wdata  (bus_wdata),
        .evt    ({tmr1_evt, tmr0_evt, ext_evt}),
        .ret_en (ret_en),
        .arb    (arb),
        .q      (cur)
    );

    pic_arbiter u_arb (
        .cur        (cur),
        .phase      (phase_t2),
        .stack_full (stack_full),
        .arb        (arb)
    );

    assign bus_rdata = hit ? DW'(cur) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_ack <= 1'b0;
            irq_vec <= '0;
        end else begin
            irq_ack <= arb.grant;
            if (arb.grant) begin
                irq_vec <= arb.vec;
            end
        end
    end

    always_comb begin
        p_pad_zero_r2: assert (bus_rdata[7] == 1'b0);
    end

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);
    p_gie_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> !cur.gie);
    p_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> $past(phase_t2));
    p_stack_r8: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> !$past(stack_full));
    p_vec_r4: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (irq_vec == 8'h04 || irq_vec == 8'h08 || irq_vec == 8'h0C));

endmodule

// File: tb/prio_irq_unit_test.sv
module prio_irq_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h0B;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_evt = 1'b0, tmr0_evt = 1'b0, tmr1_evt = 1'b0;
    logic       phase_t2 = 1'b0, stack_full = 1'b0, ret_en = 1'b0;
    logic       irq_ack;
    logic [7:0] irq_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    prio_irq_unit uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_evt(ext_evt),
        .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt), .phase_t2(phase_t2),
        .stack_full(stack_full), .ret_en(ret_en), .irq_ack(irq_ack),
        .irq_vec(irq_vec)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every acknowledge must match the next queued vector
    always @(negedge clk) begin
        if (!rst && irq_ack) begin
            if (exp_q.size() == 0) begin
                check("R7/R8/R11 unexpected ack", 8'h01, 8'h00);
            end else begin
                check("R4 vector", irq_vec, exp_q.pop_front());
            end
        end
    end

    task automatic rd(string tag, logic [7:0] addr, logic [7:0] exp);
        bus_addr = addr;
        #1;
        check(tag, bus_rdata, exp);
        bus_addr = 8'h0B;
    endtask

    task automatic wr(logic [7:0] addr, logic [7:0] d);
        bus_addr = addr; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h0B;
    endtask

    task automatic evt(logic e, logic t0, logic t1);
        ext_evt = e; tmr0_evt = t0; tmr1_evt = t1;
        @(negedge clk);
        ext_evt = 1'b0; tmr0_evt = 1'b0; tmr1_evt = 1'b0;
    endtask

    // driver: queue expectation, pulse strobe, check ack in following cycle
    task automatic strobe(string tag, logic exp_ack, logic [7:0] exp_vec);
        if (exp_ack) exp_q.push_back(exp_vec);
        phase_t2 = 1'b1;
        @(negedge clk);
        phase_t2 = 1'b0;
        check(tag, {7'b0, irq_ack}, {7'b0, exp_ack});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        rd("R1 reset reg", 8'h0B, 8'h00);
        check("R1 reset ack", {7'b0, irq_ack}, 8'h00);
        // R2
        wr(8'h0B, 8'hFF);
        rd("R2 bit7 reads 0", 8'h0B, 8'h7F);
        rd("R2 other addr read", 8'h0C, 8'h00);
        wr(8'h0B, 8'h00);
        wr(8'h05, 8'hFF);
        rd("R2 other addr write ignored", 8'h0B, 8'h00);
        // R3
        wr(8'h0B, 8'h0E);
        evt(1'b0, 1'b0, 1'b1);
        rd("R3 flag set", 8'h0B, 8'h4E);
        repeat (4) @(negedge clk);
        rd("R3 flag held", 8'h0B, 8'h4E);
        wr(8'h0B, 8'h0E);
        rd("R3 sw clear", 8'h0B, 8'h0E);
        // R7
        evt(1'b1, 1'b0, 1'b0);
        strobe("R7 gie masks", 1'b0, 8'h00);
        rd("R7 flag latched while masked", 8'h0B, 8'h1E);
        wr(8'h0B, 8'h1D);
        strobe("R7 source enable masks", 1'b0, 8'h00);
        rd("R7 state kept", 8'h0B, 8'h1D);
        // R4 R5 R6
        wr(8'h0B, 8'h0F);
        evt(1'b1, 1'b1, 1'b1);
        rd("R3 all flags", 8'h0B, 8'h7F);
        repeat (3) @(negedge clk);
        check("R5 no ack without strobe", {7'b0, irq_ack}, 8'h00);
        strobe("R4 ext first", 1'b1, 8'h04);
        rd("R6 gie and winner cleared", 8'h0B, 8'h6E);
        @(negedge clk);
        check("R6 ack one cycle", {7'b0, irq_ack}, 8'h00);
        // R11 R9
        strobe("R11 held off", 1'b0, 8'h00);
        ret_en = 1'b1;
        @(negedge clk);
        ret_en = 1'b0;
        rd("R9 ret sets gie", 8'h0B, 8'h6F);
        strobe("R4 timer0 second", 1'b1, 8'h08);
        rd("R6 timer0 cleared", 8'h0B, 8'h4E);
        wr(8'h0B, 8'h4F);
        strobe("R11 write reenables timer1", 1'b1, 8'h0C);
        rd("R6 timer1 cleared", 8'h0B, 8'h0E);
        // R8
        wr(8'h0B, 8'h1F);
        stack_full = 1'b1;
        strobe("R8 stack full blocks", 1'b0, 8'h00);
        rd("R8 state kept", 8'h0B, 8'h1F);
        stack_full = 1'b0;
        strobe("R8 released", 1'b1, 8'h04);
        rd("R6 after ack", 8'h0B, 8'h0E);
        // R10
        wr(8'h0B, 8'h2E);
        bus_wdata = 8'h0E; bus_wr = 1'b1; tmr0_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tmr0_evt = 1'b0;
        rd("R10 hw set beats sw clear", 8'h0B, 8'h2E);
        repeat (2) @(negedge clk);
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule